// File: doc/BRIEF.md
# Dual Data Pointer Register File

This block holds two 16-bit data pointers behind one shared access path, plus an 8-bit auxiliary control byte whose select bit decides which pointer is live. Every pointer command issued by the surrounding core (load a 16-bit constant, add one, write the high or low byte) lands on the live pointer only. The live pointer's value and its two bytes are always visible on the outputs, together with a combinational code-read address formed by adding an 8-bit accumulator value to it.

The control byte carries the select bit, a general-purpose flag and a bit that is hard-wired to zero. Because the zero bit sits between the select bit and the flag, adding one to the whole byte flips the select bit and never carries into the flag. The core therefore swaps pointers with a plain byte increment. Decoding the instruction stream and driving the memory bus are handled elsewhere; commands arrive here as single-cycle strobes.

The pointer command applied in a cycle is picked by a small decoder with four named cases: HOLD (no strobe), LOAD (immediate load), WRITE (byte write of high, low or both bytes) and INC (increment). The decoder moves from HOLD to any of the others on the strobes of that cycle and returns to HOLD when they drop; there is no state carried between cycles.

Top module: `dptr_file`

## Requirements
- R1: After reset both pointers are 0x0000 and the control byte reads 0x00, so pointer 0 is selected.
- R2: Control bit 0 selects the pointer: 0 picks pointer 0, 1 picks pointer 1. The pointer outputs, the code address and every pointer command use the pointer selected before the clock edge; the other pointer keeps its value.
- R3: A load strobe writes the 16-bit immediate into the selected pointer at the next clock edge.
- R4: An increment strobe adds one to the selected pointer at the next edge, wrapping from 0xFFFF to 0x0000.
- R5: The high-byte write strobe replaces bits 15:8 and the low-byte write strobe replaces bits 7:0 of the selected pointer with the write byte; both strobes together write both bytes; bytes not written keep their value.
- R6: The code address equals the selected pointer plus the zero-extended accumulator, modulo 2^16, in the same cycle.
- R7: A control write stores bit 0 (select) and bit 3 (flag); the control byte reads back as {4'b0000, flag, 1'b0, 1'b0, select}, so bit 2 and all other bits ignore writes and read 0.
- R8: A control increment strobe adds one to the control byte as read: the select bit toggles and the flag is unchanged.
- R9: Priority: load wins over byte writes, byte writes win over increment; a control write wins over a control increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load immediate into selected pointer |
| ld_val | input | 16 | Immediate value |
| inc_en | input | 1 | Increment selected pointer |
| wr_hi_en | input | 1 | Write high byte of selected pointer |
| wr_lo_en | input | 1 | Write low byte of selected pointer |
| wr_byte | input | 8 | Byte written by the byte strobes |
| ctl_wr_en | input | 1 | Write the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_inc_en | input | 1 | Increment the control byte |
| acc | input | 8 | Accumulator offset for the code address |
| ptr_out | output | 16 | Selected pointer value |
| rd_hi | output | 8 | High byte of selected pointer |
| rd_lo | output | 8 | Low byte of selected pointer |
| code_addr | output | 16 | Selected pointer plus accumulator |
| ctl_rdata | output | 8 | Control byte read value |

## Verification
The bench builds the block with its default widths, a 16-bit pointer and an 8-bit offset, which is small enough to sweep every accumulator value against pointers placed at zero, mid-range and just below the wrap point, and every one of the 256 control-write values. Those widths also put the 0xFFFF-to-0x0000 increment wrap and the carry out of the code-address adder within a few cycles of a load, and let all four select/flag combinations be walked through the control increment.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    // pointer command applied in one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2,
        OP_INC   = 2'd3
    } ptr_op_e;

    localparam int BYTE_W       = 8;
    localparam int CTL_SEL_BIT  = 0;
    localparam int CTL_ZERO_BIT = 2;
    localparam int CTL_FLAG_BIT = 3;

endpackage

// File: rtl/dptr_ctl.sv
module dptr_ctl
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              inc_en,
    output logic              sel,
    output logic [BYTE_W-1:0] rdata
);

    logic              sel_q;
    logic              flag_q;
    logic [BYTE_W-1:0] cur;
    logic [BYTE_W-1:0] bumped;

    always_comb begin
        cur               = '0;
        cur[CTL_SEL_BIT]  = sel_q;
        cur[CTL_FLAG_BIT] = flag_q;
        bumped            = cur + BYTE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (wr_en) begin
            sel_q  <= wdata[CTL_SEL_BIT];
            flag_q <= wdata[CTL_FLAG_BIT];
        end else if (inc_en) begin
            sel_q  <= bumped[CTL_SEL_BIT];
            flag_q <= bumped[CTL_FLAG_BIT];
        end
    end

    assign sel   = sel_q;
    assign rdata = cur;

endmodule

// File: rtl/dptr_slot.sv
module dptr_slot
    import dptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  ptr_op_e           op,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [PTR_W-1:0]  q
);

    localparam int HI_W = PTR_W - BYTE_W;

    logic [PTR_W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (hit) begin
            unique case (op)
                OP_HOLD:  q_r <= q_r;
                OP_LOAD:  q_r <= ld_val;
                OP_WRITE: begin
                    if (wr_hi) q_r[PTR_W-1:BYTE_W] <= wr_byte[HI_W-1:0];
                    if (wr_lo) q_r[BYTE_W-1:0]     <= wr_byte;
                end
                OP_INC:   q_r <= q_r + PTR_W'(1);
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/dptr_addr.sv
module dptr_addr
    import dptr_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int OFS_W = 8
) (
    input  logic [PTR_W-1:0] base,
    input  logic [OFS_W-1:0] ofs,
    output logic [PTR_W-1:0] sum
);

    localparam int PAD_W = PTR_W - OFS_W;

    assign sum = base + {{PAD_W{1'b0}}, ofs};

endmodule

// File: rtl/dptr_file.sv
module dptr_file
    import dptr_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int OFS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              inc_en,
    input  logic              wr_hi_en,
    input  logic              wr_lo_en,
    input  logic [7:0]        wr_byte,
    input  logic              ctl_wr_en,
    input  logic [7:0]        ctl_wdata,
    input  logic              ctl_inc_en,
    input  logic [OFS_W-1:0]  acc,
    output logic [PTR_W-1:0]  ptr_out,
    output logic [PTR_W-8-1:0] rd_hi,
    output logic [7:0]        rd_lo,
    output logic [PTR_W-1:0]  code_addr,
    output logic [7:0]        ctl_rdata
);

    localparam int PTR_CNT = 2;

    logic             sel;
    ptr_op_e          op;
    logic [PTR_W-1:0] slot_q [PTR_CNT];

    // command decode: load > byte write > increment
    always_comb begin
        if (ld_en)                      op = OP_LOAD;
        else if (wr_hi_en || wr_lo_en)  op = OP_WRITE;
        else if (inc_en)                op = OP_INC;
        else                            op = OP_HOLD;
    end

    dptr_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_wr_en),
        .wdata  (ctl_wdata),
        .inc_en (ctl_inc_en),
        .sel    (sel),
        .rdata  (ctl_rdata)
    );

    for (genvar g = 0; g < PTR_CNT; g++) begin : g_slot
        dptr_slot #(.PTR_W(PTR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (sel == 1'(g)),
            .op      (op),
            .ld_val  (ld_val),
            .wr_hi   (wr_hi_en),
            .wr_lo   (wr_lo_en),
            .wr_byte (wr_byte),
            .q       (slot_q[g])
        );
    end

    assign ptr_out = slot_q[sel];
    assign rd_hi   = ptr_out[PTR_W-1:BYTE_W];
    assign rd_lo   = ptr_out[BYTE_W-1:0];

    dptr_addr #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_addr (
        .base (ptr_out),
        .ofs  (acc),
        .sum  (code_addr)
    );

endmodule

// File: rtl/dptr_file_chk.sv
module dptr_file_chk #(
    parameter int PTR_W = 16,
    parameter int OFS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_en,
    input logic [PTR_W-1:0] ld_val,
    input logic             inc_en,
    input logic             wr_hi_en,
    input logic             wr_lo_en,
    input logic             ctl_wr_en,
    input logic [7:0]       ctl_wdata,
    input logic             ctl_inc_en,
    input logic [OFS_W-1:0] acc,
    input logic [PTR_W-1:0] ptr_out,
    input logic [PTR_W-1:0] code_addr,
    input logic [7:0]       ctl_rdata
);

    logic ctl_quiet;
    assign ctl_quiet = !ctl_wr_en && !ctl_inc_en;

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ctl_quiet) |=> (ptr_out == $past(ld_val)));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !ld_en && !wr_hi_en && !wr_lo_en && ctl_quiet)
            |=> (ptr_out == PTR_W'($past(ptr_out) + PTR_W'(1))));

    // R6
    code_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_addr == PTR_W'(ptr_out + PTR_W'(acc)));

    // R7
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (ctl_rdata == ($past(ctl_wdata) & 8'h09)));

    // R8
    ctl_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_inc_en && !ctl_wr_en)
            |=> ((ctl_rdata[0] != $past(ctl_rdata[0])) && $stable(ctl_rdata[3])));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !inc_en && !wr_hi_en && !wr_lo_en && ctl_quiet) |=> $stable(ptr_out));

endmodule

bind dptr_file dptr_file_chk #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_val     (ld_val),
    .inc_en     (inc_en),
    .wr_hi_en   (wr_hi_en),
    .wr_lo_en   (wr_lo_en),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wdata  (ctl_wdata),
    .ctl_inc_en (ctl_inc_en),
    .acc        (acc),
    .ptr_out    (ptr_out),
    .code_addr  (code_addr),
    .ctl_rdata  (ctl_rdata)
);

// File: tb/dptr_file_test.sv
module dptr_file_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 0, inc_en = 0, wr_hi_en = 0, wr_lo_en = 0;
    logic [15:0] ld_val = 0;
    logic [7:0]  wr_byte = 0, ctl_wdata = 0, acc = 0;
    logic        ctl_wr_en = 0, ctl_inc_en = 0;
    logic [15:0] ptr_out, code_addr;
    logic [7:0]  rd_hi, rd_lo, ctl_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    logic [15:0] m_ptr [2];
    logic        m_sel, m_flag;

    always #(PERIOD/2) clk = ~clk;

    dptr_file uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .inc_en(inc_en), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
        .wr_byte(wr_byte), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
        .ctl_inc_en(ctl_inc_en), .acc(acc), .ptr_out(ptr_out),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .code_addr(code_addr),
        .ctl_rdata(ctl_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // one clock with the current strobes, then update model and clear strobes
    task automatic tick();
        logic [15:0] p;
        logic        s;
        logic [7:0]  c;
        s = m_sel;
        p = m_ptr[s];
        if (ld_en) p = ld_val;
        else if (wr_hi_en || wr_lo_en) begin
            if (wr_hi_en) p[15:8] = wr_byte;
            if (wr_lo_en) p[7:0]  = wr_byte;
        end else if (inc_en) p = p + 16'd1;
        m_ptr[s] = p;
        if (ctl_wr_en) begin
            m_sel  = ctl_wdata[0];
            m_flag = ctl_wdata[3];
        end else if (ctl_inc_en) begin
            c = {4'b0, m_flag, 2'b00, m_sel} + 8'd1;
            m_sel  = c[0];
            m_flag = c[3];
        end
        @(posedge clk);
        #1;
        ld_en = 0; inc_en = 0; wr_hi_en = 0; wr_lo_en = 0;
        ctl_wr_en = 0; ctl_inc_en = 0;
    endtask

    task automatic check_state(input string req);
        check(req, 32'(ptr_out), 32'(m_ptr[m_sel]));
        check(req, 32'(ctl_rdata), 32'({4'b0, m_flag, 2'b00, m_sel}));
    endtask

    task automatic set_ctl(input logic [7:0] v);
        ctl_wr_en = 1; ctl_wdata = v; tick();
    endtask

    task automatic load(input logic [15:0] v);
        ld_en = 1; ld_val = v; tick();
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0; m_flag = 0;
        #(PERIOD*2 + 2);
        rst_n = 1;
        #(PERIOD);

        // R1 reset state of both pointers and control byte
        check("R1", 32'(ptr_out), 0);
        check("R1", 32'(ctl_rdata), 0);
        set_ctl(8'h01);
        check("R1", 32'(ptr_out), 0);
        set_ctl(8'h00);

        // R3 / R2 load each pointer, other keeps value
        load(16'h1234);
        check_state("R3");
        set_ctl(8'h01);
        check("R2", 32'(ptr_out), 0);
        load(16'hBEEF);
        check_state("R3");
        set_ctl(8'h00);
        check("R2", 32'(ptr_out), 32'h1234);
        check("R2", 32'(rd_hi), 32'h12);
        check("R2", 32'(rd_lo), 32'h34);

        // R5 byte writes
        wr_hi_en = 1; wr_byte = 8'hA5; tick();
        check("R5", 32'(ptr_out), 32'hA534);
        wr_lo_en = 1; wr_byte = 8'h5A; tick();
        check("R5", 32'(ptr_out), 32'hA55A);
        wr_hi_en = 1; wr_lo_en = 1; wr_byte = 8'h77; tick();
        check("R5", 32'(ptr_out), 32'h7777);
        set_ctl(8'h01);
        check("R5", 32'(ptr_out), 32'hBEEF);
        set_ctl(8'h00);

        // R4 increment with wrap
        load(16'hFFFE);
        for (int i = 0; i < 3; i++) begin
            inc_en = 1; tick();
            check_state("R4");
        end
        check("R4", 32'(ptr_out), 32'h0001);

        // R9 priority
        ld_en = 1; ld_val = 16'h4444; wr_hi_en = 1; wr_byte = 8'h99; inc_en = 1; tick();
        check("R9", 32'(ptr_out), 32'h4444);
        wr_lo_en = 1; wr_byte = 8'h10; inc_en = 1; tick();
        check("R9", 32'(ptr_out), 32'h4410);
        ctl_wr_en = 1; ctl_wdata = 8'h08; ctl_inc_en = 1; tick();
        check("R9", 32'(ctl_rdata), 32'h08);
        // R2 pointer command in same cycle as select change uses old select
        ctl_inc_en = 1; inc_en = 1; tick();
        check_state("R2");
        check("R2", 32'(m_ptr[0]), 32'h4411);

        // R6 sweep accumulator over several bases
        for (int b = 0; b < 4; b++) begin
            logic [15:0] base;
            base = (b == 0) ? 16'h0000 : (b == 1) ? 16'h8000 :
                   (b == 2) ? 16'hFF80 : 16'hFFFF;
            load(base);
            for (int a = 0; a < 256; a++) begin
                acc = 8'(a);
                #1;
                check("R6", 32'(code_addr), 32'((base + 16'(a)) & 16'hFFFF));
            end
        end

        // R7 all control write values
        for (int v = 0; v < 256; v++) begin
            set_ctl(8'(v));
            check("R7", 32'(ctl_rdata), 32'(v & 8'h09));
        end

        // R8 control increment over every select/flag pair
        for (int v = 0; v < 4; v++) begin
            set_ctl((v[1] ? 8'h08 : 8'h00) | (v[0] ? 8'h01 : 8'h00));
            ctl_inc_en = 1; tick();
            check("R8", 32'(ctl_rdata[0]), 32'(!v[0]));
            check("R8", 32'(ctl_rdata[3]), 32'(v[1]));
            check_state("R8");
        end

        finish_run();
    end

endmodule